// File: doc/BRIEF.md
# Split Completion Streaming Sequencer

This block sits between a request splitter and the bus that issued a long split read. The splitter breaks the read into 64-byte line requests and gives each one a buffer slot, chosen as the line's sequence number modulo the slot count. Read responses come back as four 128-bit beats per line, in any line order, and are written into those slots. The sequencer then streams the lines back to the bus as split completions, always in ascending line order. Each slot goes back to the splitter once its line has been sent.

A completion opens as soon as the line it needs is present. It does not wait for the rest of the request. Lines that land while the completion is open are streamed within it. Inside a 128-byte address block the sequencer inserts idle cycles if the next line is late, and the completion stays open. On the last beat before a 128-byte address boundary the sequencer decides whether to go on. If the next line is not yet stored, the completion is closed there. A new completion opens when that line arrives. Each completion carries the byte count still owed and the address of its first line.

Top module: `scs_top`

## Requirements
- R1: While reset is asserted and after its release, with no request, cpl_valid_o, cpl_start_o, cpl_end_o and free_valid_o are low.
- R2: Every line is output as four consecutive beats, in the order they were written to its slot, with lines in ascending sequence order.
- R3: A completion's first beat has cpl_start_o high. It is the first beat of a line. It carries cpl_bytes_o = (lines in request − line sequence) × 64 and cpl_addr_o = byte address of that line. Both values are held until the completion ends.
- R4: A line that is not followed by a 128-byte boundary never ends a completion (unless it is the last line). If the next line is late, idle cycles are inserted and the completion stays open. Lines present in time are sent with no gap.
- R5: On the fourth beat of a line whose next line address is a multiple of 128 bytes, cpl_end_o is raised if the next line is not fully stored as of that cycle. A final response beat sampled on that same clock edge counts as not stored.
- R6: After such a cut, no beat is output until the next line is fully stored. Then a new completion starts with that line.
- R7: The fourth beat of the request's last line raises cpl_end_o. The block then accepts a new request in the following cycle.
- R8: free_valid_o pulses together with every line's fourth beat. free_slot_o equals that line's sequence number modulo the slot count.
- R9: A request presented while a request is in progress is ignored, and so is a request for zero lines.
- R10: Lines stored out of order, or before the request, are delivered in ascending order within one completion when all are present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Start a split read |
| req_line_i | input | ADDR_W-6 | Line address (byte address / 64) of the first line |
| req_lines_i | input | $clog2(MAX_LINES+1) | Number of lines in the request |
| rsp_valid_i | input | 1 | Response beat valid |
| rsp_slot_i | input | $clog2(SLOTS) | Target slot (sequence modulo SLOTS) |
| rsp_data_i | input | 128 | Response beat data |
| rsp_last_i | input | 1 | Fourth beat of the line |
| cpl_valid_o | output | 1 | Completion beat valid |
| cpl_start_o | output | 1 | First beat of a completion |
| cpl_end_o | output | 1 | Last beat of a completion |
| cpl_data_o | output | 128 | Completion beat data |
| cpl_bytes_o | output | $clog2(MAX_LINES+1)+6 | Bytes remaining, from the first beat of the completion |
| cpl_addr_o | output | ADDR_W | Byte address of the completion's first line |
| free_valid_o | output | 1 | Slot released |
| free_slot_o | output | $clog2(SLOTS) | Released slot index |

## Verification
The case that matters most is a collision between two events: the final beat of the next line's response being stored, and the boundary decision on the fourth beat of the current line. The bench watches the output until the third beat of the boundary line appears. It then drives the missing final beat so that it is sampled on the very edge that makes the decision. The completion must be cut, and a fresh completion with the reduced byte count must follow. The same stimulus placed one cycle earlier must let the completion run through unbroken. These two cases fix the exact cycle in which arrival is judged.

// File: rtl/scs_pkg.sv
package scs_pkg;
  localparam int DATA_W     = 128;
  localparam int BEATS      = 4;
  localparam int BEAT_W     = $clog2(BEATS);
  localparam int LINE_SHIFT = 6;
endpackage

// File: rtl/scs_line_store.sv
module scs_line_store
  import scs_pkg::*;
#(
  parameter int SLOTS  = 4,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [SLOT_W-1:0] wr_slot_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_last_i,
  input  logic [SLOT_W-1:0] rd_slot_i,
  input  logic [BEAT_W-1:0] rd_beat_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              clr_valid_i,
  input  logic [SLOT_W-1:0] clr_slot_i,
  output logic [SLOTS-1:0]  full_o
);
  // SLOTS must be a power of two: slot and beat concatenate into the row index
  localparam int ROWS = SLOTS * BEATS;

  logic [DATA_W-1:0]            mem_q [ROWS];
  logic [SLOTS-1:0][BEAT_W-1:0] wbeat;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [BEAT_W-1:0] beat_q;
    logic              full_q;
    logic              hit;
    assign hit = wr_valid_i && (wr_slot_i == SLOT_W'(s));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        beat_q <= '0;
        full_q <= 1'b0;
      end else begin
        if (hit) beat_q <= wr_last_i ? '0 : beat_q + 1'b1;
        if (hit && wr_last_i) full_q <= 1'b1;
        else if (clr_valid_i && clr_slot_i == SLOT_W'(s)) full_q <= 1'b0;
      end
    end
    assign wbeat[s]  = beat_q;
    assign full_o[s] = full_q;
  end

  always_ff @(posedge clk_i) begin
    if (wr_valid_i) mem_q[{wr_slot_i, wbeat[wr_slot_i]}] <= wr_data_i;
  end

  assign rd_data_o = mem_q[{rd_slot_i, rd_beat_i}];
endmodule

// File: rtl/scs_sequencer.sv
module scs_sequencer
  import scs_pkg::*;
#(
  parameter int SLOTS   = 4,
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 7,
  parameter int SLOT_W  = $clog2(SLOTS),
  parameter int LADDR_W = ADDR_W - LINE_SHIFT,
  parameter int BYTES_W = CNT_W + LINE_SHIFT
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [LADDR_W-1:0] req_line_i,
  input  logic [CNT_W-1:0]   req_lines_i,
  input  logic [SLOTS-1:0]   full_i,
  output logic [SLOT_W-1:0]  rd_slot_o,
  output logic [BEAT_W-1:0]  rd_beat_o,
  input  logic [DATA_W-1:0]  rd_data_i,
  output logic               clr_valid_o,
  output logic [SLOT_W-1:0]  clr_slot_o,
  output logic               cpl_valid_o,
  output logic               cpl_start_o,
  output logic               cpl_end_o,
  output logic [DATA_W-1:0]  cpl_data_o,
  output logic [BYTES_W-1:0] cpl_bytes_o,
  output logic [ADDR_W-1:0]  cpl_addr_o,
  output logic               free_valid_o,
  output logic [SLOT_W-1:0]  free_slot_o
);
  logic               active_q, open_q;
  logic [CNT_W-1:0]   seq_q, total_q;
  logic [BEAT_W-1:0]  beat_q;
  logic [LADDR_W-1:0] base_q;

  logic [SLOT_W-1:0]  cur_slot, nxt_slot;
  logic [LADDR_W-1:0] cur_line;
  logic               line_end, last_line, at_bound, go, cut, opening;

  always_comb begin
    cur_slot  = seq_q[SLOT_W-1:0];
    nxt_slot  = cur_slot + 1'b1;
    cur_line  = base_q + LADDR_W'(seq_q);
    at_bound  = cur_line[0];  // odd line: next line starts a 128-byte block
    line_end  = beat_q == BEAT_W'(BEATS - 1);
    last_line = seq_q == total_q - 1'b1;
    // a line is only entered when fully stored, then runs without gaps
    go        = active_q && (beat_q != '0 || full_i[cur_slot]);
    cut       = line_end && (last_line || (at_bound && !full_i[nxt_slot]));
    opening   = go && !open_q && beat_q == '0;
  end

  assign rd_slot_o   = cur_slot;
  assign rd_beat_o   = beat_q;
  assign clr_valid_o = go && line_end;
  assign clr_slot_o  = cur_slot;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q     <= 1'b0;
      open_q       <= 1'b0;
      seq_q        <= '0;
      total_q      <= '0;
      beat_q       <= '0;
      base_q       <= '0;
      cpl_valid_o  <= 1'b0;
      cpl_start_o  <= 1'b0;
      cpl_end_o    <= 1'b0;
      cpl_data_o   <= '0;
      cpl_bytes_o  <= '0;
      cpl_addr_o   <= '0;
      free_valid_o <= 1'b0;
      free_slot_o  <= '0;
    end else begin
      cpl_valid_o  <= go;
      cpl_start_o  <= opening;
      cpl_end_o    <= go && cut;
      free_valid_o <= go && line_end;
      if (go) cpl_data_o <= rd_data_i;
      if (go && line_end) free_slot_o <= cur_slot;
      if (opening) begin
        cpl_bytes_o <= {total_q - seq_q, {LINE_SHIFT{1'b0}}};
        cpl_addr_o  <= {cur_line, {LINE_SHIFT{1'b0}}};
      end
      if (!active_q) begin
        if (req_valid_i && req_lines_i != '0) begin
          active_q <= 1'b1;
          open_q   <= 1'b0;
          seq_q    <= '0;
          beat_q   <= '0;
          total_q  <= req_lines_i;
          base_q   <= req_line_i;
        end
      end else if (go) begin
        beat_q <= beat_q + 1'b1;
        open_q <= !cut;
        if (line_end) begin
          seq_q <= seq_q + 1'b1;
          if (last_line) active_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/scs_top.sv
module scs_top
  import scs_pkg::*;
#(
  parameter int SLOTS     = 4,
  parameter int ADDR_W    = 32,
  parameter int MAX_LINES = 64,
  localparam int SLOT_W   = $clog2(SLOTS),
  localparam int CNT_W    = $clog2(MAX_LINES + 1),
  localparam int LADDR_W  = ADDR_W - LINE_SHIFT,
  localparam int BYTES_W  = CNT_W + LINE_SHIFT
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [LADDR_W-1:0] req_line_i,
  input  logic [CNT_W-1:0]   req_lines_i,
  input  logic               rsp_valid_i,
  input  logic [SLOT_W-1:0]  rsp_slot_i,
  input  logic [DATA_W-1:0]  rsp_data_i,
  input  logic               rsp_last_i,
  output logic               cpl_valid_o,
  output logic               cpl_start_o,
  output logic               cpl_end_o,
  output logic [DATA_W-1:0]  cpl_data_o,
  output logic [BYTES_W-1:0] cpl_bytes_o,
  output logic [ADDR_W-1:0]  cpl_addr_o,
  output logic               free_valid_o,
  output logic [SLOT_W-1:0]  free_slot_o
);
  logic [SLOTS-1:0]  full;
  logic [SLOT_W-1:0] rd_slot, clr_slot;
  logic [BEAT_W-1:0] rd_beat;
  logic [DATA_W-1:0] rd_data;
  logic              clr_valid;

  scs_line_store #(.SLOTS(SLOTS)) u_store (
    .clk_i, .rst_ni,
    .wr_valid_i (rsp_valid_i),
    .wr_slot_i  (rsp_slot_i),
    .wr_data_i  (rsp_data_i),
    .wr_last_i  (rsp_last_i),
    .rd_slot_i  (rd_slot),
    .rd_beat_i  (rd_beat),
    .rd_data_o  (rd_data),
    .clr_valid_i(clr_valid),
    .clr_slot_i (clr_slot),
    .full_o     (full)
  );

  scs_sequencer #(.SLOTS(SLOTS), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
    .clk_i, .rst_ni,
    .req_valid_i, .req_line_i, .req_lines_i,
    .full_i      (full),
    .rd_slot_o   (rd_slot),
    .rd_beat_o   (rd_beat),
    .rd_data_i   (rd_data),
    .clr_valid_o (clr_valid),
    .clr_slot_o  (clr_slot),
    .cpl_valid_o, .cpl_start_o, .cpl_end_o, .cpl_data_o,
    .cpl_bytes_o, .cpl_addr_o, .free_valid_o, .free_slot_o
  );
endmodule

// File: rtl/scs_checker.sv
module scs_checker #(
  parameter int BYTES_W = 13
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cpl_valid_o,
  input logic               cpl_start_o,
  input logic               cpl_end_o,
  input logic [BYTES_W-1:0] cpl_bytes_o,
  input logic               free_valid_o
);
  logic [1:0] beat_q;
  logic       open_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_q <= '0;
      open_q <= 1'b0;
    end else begin
      if (cpl_valid_o) beat_q <= beat_q + 1'b1;
      if (cpl_end_o) open_q <= 1'b0;
      else if (cpl_start_o) open_q <= 1'b1;
    end
  end

  a_r3_start_has_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpl_start_o |-> cpl_valid_o);
  a_r3_start_line_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpl_start_o |-> beat_q == 2'd0);
  a_r3_no_nested_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpl_start_o |-> !open_q);
  a_r3_bytes_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_q && !cpl_start_o) |-> $stable(cpl_bytes_o));
  a_r5_end_on_line_tail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpl_end_o |-> (cpl_valid_o && beat_q == 2'd3));
  a_r8_free_on_tail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_valid_o |-> (cpl_valid_o && beat_q == 2'd3));
  a_r8_tail_frees: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpl_valid_o && beat_q == 2'd3) |-> free_valid_o);
endmodule

bind scs_top scs_checker #(.BYTES_W(BYTES_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cpl_valid_o (cpl_valid_o),
  .cpl_start_o (cpl_start_o),
  .cpl_end_o   (cpl_end_o),
  .cpl_bytes_o (cpl_bytes_o),
  .free_valid_o(free_valid_o)
);

// File: tb/scs_top_test.sv
module scs_top_test;
  localparam int SLOTS = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic [25:0]  req_line = '0;
  logic [6:0]   req_lines = '0;
  logic         rsp_valid = 1'b0;
  logic [1:0]   rsp_slot = '0;
  logic [127:0] rsp_data = '0;
  logic         rsp_last = 1'b0;
  logic         cpl_valid, cpl_start, cpl_end, free_valid;
  logic [127:0] cpl_data;
  logic [12:0]  cpl_bytes;
  logic [31:0]  cpl_addr;
  logic [1:0]   free_slot;

  always #10 clk = ~clk;

  scs_top uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_line_i(req_line), .req_lines_i(req_lines),
    .rsp_valid_i(rsp_valid), .rsp_slot_i(rsp_slot), .rsp_data_i(rsp_data), .rsp_last_i(rsp_last),
    .cpl_valid_o(cpl_valid), .cpl_start_o(cpl_start), .cpl_end_o(cpl_end), .cpl_data_o(cpl_data),
    .cpl_bytes_o(cpl_bytes), .cpl_addr_o(cpl_addr), .free_valid_o(free_valid), .free_slot_o(free_slot)
  );

  int checks = 0, errors = 0, cyc = 0;
  int cur_tag = 0, cur_lines = 0;
  int unsigned cur_base = 0;
  int mon_beats = 0, mon_starts = 0, mon_ends = 0, mon_frees = 0;
  int first_t = 0, last_t = 0;
  int end_line [8];

  function automatic logic [127:0] pat(input int t, input int l, input int b);
    return {4{t[7:0], l[7:0], b[7:0], 8'hA5}};
  endfunction

  task automatic chk(input bit ok, input string what, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // Output monitor: data order (R2), start fields (R3), end/free alignment (R5, R8)
  always @(negedge clk) begin
    if (rst_n && cpl_valid) begin
      automatic int l = mon_beats / 4;
      automatic int b = mon_beats % 4;
      chk(cpl_data == pat(cur_tag, l, b), "R2 beat data", cpl_data, pat(cur_tag, l, b));
      if (cpl_start) begin
        mon_starts++;
        chk(b == 0, "R3 start on first beat", b, 0);
        chk(cpl_bytes == 13'((cur_lines - l) * 64), "R3 remaining bytes", cpl_bytes, (cur_lines - l) * 64);
        chk(cpl_addr == cur_base + 32'(l * 64), "R3 start address", cpl_addr, cur_base + l * 64);
      end
      if (cpl_end) begin
        if (mon_ends < 8) end_line[mon_ends] = l;
        mon_ends++;
      end
      if (free_valid) begin
        mon_frees++;
        chk(free_slot == 2'(l % SLOTS) && b == 3, "R8 free slot", free_slot, l % SLOTS);
      end
      if (mon_beats == 0) first_t = cyc;
      last_t = cyc;
      mon_beats++;
    end
  end

  task automatic new_scn(input int tag, input int unsigned base, input int lines);
    @(posedge clk);
    cur_tag = tag; cur_base = base; cur_lines = lines;
    mon_beats = 0; mon_starts = 0; mon_ends = 0; mon_frees = 0;
    @(negedge clk);
  endtask

  task automatic put_beat(input int l, input int b);
    rsp_valid = 1'b1; rsp_slot = 2'(l % SLOTS); rsp_data = pat(cur_tag, l, b); rsp_last = (b == 3);
    @(negedge clk);
    rsp_valid = 1'b0; rsp_last = 1'b0;
  endtask

  task automatic put_line(input int l);
    for (int b = 0; b < 4; b++) put_beat(l, b);
  endtask

  task automatic issue(input int unsigned base, input int lines);
    req_valid = 1'b1; req_line = 26'(base >> 6); req_lines = 7'(lines);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_beats(input int n);
    for (int i = 0; i < 200 && mon_beats < n; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_show(input int l, input int b);
    for (int i = 0; i < 200; i++) begin
      if (cpl_valid && cpl_data == pat(cur_tag, l, b)) break;
      @(negedge clk);
    end
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk({cpl_valid, cpl_start, cpl_end, free_valid} == 4'b0, "R1 outputs in reset", {cpl_valid, cpl_start, cpl_end, free_valid}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({cpl_valid, cpl_start, cpl_end, free_valid} == 4'b0, "R1 idle after reset", {cpl_valid, cpl_start, cpl_end, free_valid}, 0);

    // R10, R4: all lines stored out of order before the request
    new_scn(1, 32'h1000, 4);
    put_line(3); put_line(1); put_line(2); put_line(0);
    issue(32'h1000, 4);
    wait_beats(16);
    chk(mon_beats == 16, "R10 beats delivered", mon_beats, 16);
    chk(mon_starts == 1 && mon_ends == 1, "R10 single completion", {mon_starts, mon_ends}, {32'd1, 32'd1});
    chk(last_t - first_t == 15, "R4 no gaps when lines present", last_t - first_t, 15);
    chk(mon_frees == 4, "R8 all slots freed", mon_frees, 4);

    // R4 wait state inside a 128B block, R5 cut at boundary, R6 restart, R9 request while busy
    new_scn(2, 32'h2000, 4);
    issue(32'h2000, 4);
    repeat (3) @(negedge clk);
    chk(mon_beats == 0, "R6 no beat before first line", mon_beats, 0);
    put_line(0);
    repeat (12) @(negedge clk);
    chk(mon_beats == 4 && mon_ends == 0, "R4 open across late line", {mon_beats, mon_ends}, {32'd4, 32'd0});
    issue(32'h9000, 2);
    put_line(1);
    repeat (10) @(negedge clk);
    chk(mon_beats == 8 && mon_ends == 1 && end_line[0] == 1, "R5 cut at boundary", {mon_beats, mon_ends}, {32'd8, 32'd1});
    put_line(3);
    repeat (8) @(negedge clk);
    chk(mon_beats == 8, "R6 wait for next in order", mon_beats, 8);
    put_line(2);
    wait_beats(16);
    chk(mon_starts == 2 && mon_ends == 2 && end_line[1] == 3, "R6 restart, R7 final end", {mon_starts, mon_ends}, {32'd2, 32'd2});
    chk(mon_beats == 16, "R9 busy request ignored", mon_beats, 16);

    // R5: odd first line sits right before a boundary
    new_scn(3, 32'h3040, 3);
    put_line(0);
    issue(32'h3040, 3);
    repeat (10) @(negedge clk);
    chk(mon_beats == 4 && mon_ends == 1 && mon_starts == 1, "R5 immediate cut", {mon_beats, mon_ends}, {32'd4, 32'd1});
    put_line(1); put_line(2);
    wait_beats(12);
    chk(mon_starts == 2 && mon_ends == 2, "R6 second completion", {mon_starts, mon_ends}, {32'd2, 32'd2});

    // R8: request longer than the slot count, refilled on each free
    new_scn(4, 32'h0, 12);
    for (int l = 0; l < 4; l++) put_line(l);
    issue(32'h0, 12);
    for (int l = 4; l < 12; l++) begin
      for (int i = 0; i < 200 && mon_frees < l - 3; i++) @(negedge clk);
      put_line(l);
    end
    wait_beats(48);
    chk(mon_beats == 48 && mon_frees == 12, "R8 slot reuse", {mon_beats, mon_frees}, {32'd48, 32'd12});
    chk(mon_starts == mon_ends, "R7 completions closed", mon_ends, mon_starts);

    // R5: final beat of next line sampled on the decision edge counts as absent
    new_scn(5, 32'h0, 4);
    put_line(0); put_line(1);
    for (int b = 0; b < 3; b++) put_beat(2, b);
    issue(32'h0, 4);
    wait_show(1, 2);
    put_beat(2, 3);
    repeat (3) @(negedge clk);
    chk(mon_ends == 1 && end_line[0] == 1, "R5 same-edge arrival cuts", mon_ends, 1);
    put_line(3);
    wait_beats(16);
    chk(mon_starts == 2 && mon_ends == 2, "R6 restart after same-edge cut", {mon_starts, mon_ends}, {32'd2, 32'd2});

    // R5 counterpart: one cycle earlier keeps the completion open
    new_scn(6, 32'h0, 4);
    put_line(0); put_line(1); put_line(3);
    for (int b = 0; b < 3; b++) put_beat(2, b);
    issue(32'h0, 4);
    wait_show(1, 1);
    put_beat(2, 3);
    wait_beats(16);
    chk(mon_starts == 1 && mon_ends == 1, "R5 early arrival continues", {mon_starts, mon_ends}, {32'd1, 32'd1});

    // R9 zero-line request, R7 single-line completion
    new_scn(7, 32'h7000, 1);
    put_line(0);
    issue(32'h7000, 0);
    repeat (8) @(negedge clk);
    chk(mon_beats == 0, "R9 zero-line request ignored", mon_beats, 0);
    issue(32'h7000, 1);
    wait_beats(4);
    chk(mon_beats == 4 && mon_starts == 1 && mon_ends == 1, "R7 single line start and end", {mon_starts, mon_ends}, {32'd1, 32'd1});
    repeat (4) @(negedge clk);
    chk(cpl_valid == 1'b0, "R7 idle after last line", cpl_valid, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule